// File: doc/BRIEF.md
# Serial Word Loopback Self-Test Checker

This block sits beside a serial-bus word encoder and its decoder while they transmit a message. Every word handed to the encoder must come back as an echo from the decoder. The block checks each echo for a well-formed frame. It compares the echo of the message's final word bit by bit with the word that was sent. It also runs a watchdog on how long the transmitter stays on. Any of these faults sets a sticky loop-test-fail bit and a cause field for the current message. If interrupts are enabled, the first fault of a message also raises a one-cycle interrupt request.

Echoes arrive on one of two paths. The line path runs through the bus transceiver and is used in online mode. The wrap path is the decoder's internal loop and is used in offline mode, which leaves the transceiver out of the test. A frame is 16 data bits plus one odd-parity bit, behind a sync field. The decoder reports sync, Manchester-encoding and bit-count errors as flags beside the data. The block works out the parity itself.

Sent words enter on a valid/ready stream. The block accepts a new word only when no earlier echo is still awaited, so exactly one word is in flight at a time. While `tx_ready` is low, the encoder must hold `tx_valid`, `tx_data` and `tx_last` steady. Echo inputs have no back-pressure and are sampled on every clock. An echo that arrives while no word is awaited is ignored.

Top module: `lbt_loopback_checker`

## Requirements
- R1: After reset, `loop_fail`, `fail_cause` and `irq` are 0 and `tx_ready` is 1.
- R2: An awaited echo fails format, setting `fail_cause[0]`, when it has a sync, encoding or bit-count error flag, or when its 16 data bits together with its parity bit hold an even number of ones.
- R3: A well-formed echo of a word sent with `tx_last`=1 whose data differs from the sent data sets `fail_cause[1]`. A data mismatch on any other word has no effect.
- R4: If no echo arrives by the ECHO_WIN-th clock edge after the word was accepted, `fail_cause[0]` is set at that edge. An echo sampled at that same edge is still checked normally.
- R5: With `wdog_limit`=N>0, `fail_cause[2]` is set at the N-th consecutive clock edge that samples `tx_active` high.
- R6: An edge that samples `tx_active` low restarts the watchdog count. `wdog_limit`=0 disables the watchdog.
- R7: Cause bits are sticky and accumulate within a message. A `msg_start` pulse clears all cause bits and drops any awaited echo. `loop_fail` is the OR of the cause bits.
- R8: When `irq_en` is 1, `irq` pulses for one cycle in the cycle in which the first cause bit of a message is set. It does not pulse again until the next `msg_start`. When `irq_en` is 0, failures are still recorded but `irq` stays 0.
- R9: With `offline_sel`=0 only the line-path echo is checked. With `offline_sel`=1 only the wrap-path echo is checked. The other path is ignored.
- R10: With `test_en`=0 no cause bit is set.
- R11: `tx_ready` is 0 from the cycle after a word is accepted until the cycle after its echo is resolved, and is also 0 while `msg_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | Enables recording of loop-test faults |
| offline_sel | input | 1 | 0 selects the line echo path, 1 selects the wrap echo path |
| irq_en | input | 1 | Enables the interrupt request |
| msg_start | input | 1 | Pulse at the start of a new message |
| tx_valid | input | 1 | Sent word valid |
| tx_ready | output | 1 | Checker can accept a sent word |
| tx_data | input | DW | Data of the sent word |
| tx_last | input | 1 | Sent word is the last word of the message |
| tx_active | input | 1 | Transmitter is driving |
| wdog_limit | input | WD_W | Watchdog limit in clocks, 0 disables it |
| line_valid | input | 1 | Line-path echo valid |
| line_data | input | DW | Line-path echo data |
| line_par | input | 1 | Line-path echo parity bit |
| line_sync_err | input | 1 | Line-path echo sync error |
| line_enc_err | input | 1 | Line-path echo encoding error |
| line_cnt_err | input | 1 | Line-path echo bit-count error |
| wrap_valid | input | 1 | Wrap-path echo valid |
| wrap_data | input | DW | Wrap-path echo data |
| wrap_par | input | 1 | Wrap-path echo parity bit |
| wrap_sync_err | input | 1 | Wrap-path echo sync error |
| wrap_enc_err | input | 1 | Wrap-path echo encoding error |
| wrap_cnt_err | input | 1 | Wrap-path echo bit-count error |
| loop_fail | output | 1 | Loop-test-fail status bit |
| fail_cause | output | 3 | Sticky causes: bit 0 format or no echo, bit 1 compare, bit 2 watchdog |
| irq | output | 1 | Interrupt request pulse |

## Verification
On every cycle, the assertions check the protocol and status invariants. Only one word is in flight after a handshake. Cause bits are sticky and cleared by `msg_start`. The interrupt is a single gated pulse on the first fault. Nothing is recorded while the test is disabled. A watchdog cause appears only after the transmitter was on. The bench scenarios are needed for the data-dependent outcomes: which error flag or parity pattern counts as a bad frame, that only the last word is compared, and the exact edge at which the echo window and the watchdog expire. They also show that the unselected echo path is ignored.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int CAUSE_FMT = 0;
  localparam int CAUSE_CMP = 1;
  localparam int CAUSE_WDG = 2;
  localparam int N_CAUSE   = 3;

  localparam int PATH_LINE = 0;
  localparam int PATH_WRAP = 1;
  localparam int N_PATH    = 2;
endpackage

// File: rtl/lbt_echo_select.sv
module lbt_echo_select #(
  parameter int DW = 16
) (
  input  logic          offline_sel,
  input  logic [1:0]    src_valid,
  input  logic [DW-1:0] src_data [2],
  input  logic [1:0]    src_par,
  input  logic [1:0]    src_flag_err,
  output logic          echo_valid,
  output logic [DW-1:0] echo_data,
  output logic          echo_bad
);
  import lbt_pkg::*;

  logic [N_PATH-1:0] frame_bad;

  generate
    for (genvar p = 0; p < N_PATH; p++) begin : g_path
      // odd parity over data and parity bit is required
      assign frame_bad[p] = src_flag_err[p] | ~(^{src_data[p], src_par[p]});
    end
  endgenerate

  always_comb begin
    if (offline_sel) begin
      echo_valid = src_valid[PATH_WRAP];
      echo_data  = src_data[PATH_WRAP];
      echo_bad   = frame_bad[PATH_WRAP];
    end else begin
      echo_valid = src_valid[PATH_LINE];
      echo_data  = src_data[PATH_LINE];
      echo_bad   = frame_bad[PATH_LINE];
    end
  end
endmodule

// File: rtl/lbt_echo_tracker.sv
module lbt_echo_tracker #(
  parameter int DW       = 16,
  parameter int ECHO_WIN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  input  logic          echo_valid,
  input  logic [DW-1:0] echo_data,
  input  logic          echo_bad,
  output logic          fmt_evt,
  output logic          cmp_evt
);
  localparam int CW = (ECHO_WIN > 2) ? $clog2(ECHO_WIN) : 1;
  localparam logic [CW-1:0] WIN_END = CW'(ECHO_WIN - 1);

  logic          pending;
  logic [CW-1:0] wait_cnt;
  logic [DW-1:0] exp_data;
  logic          exp_last;
  logic          accept;
  logic          expired;

  assign tx_ready = !pending && !clear;
  assign accept   = tx_valid && tx_ready;
  assign expired  = pending && !echo_valid && (wait_cnt == WIN_END);

  assign fmt_evt = pending && !clear && ((echo_valid && echo_bad) || expired);
  assign cmp_evt = pending && !clear && echo_valid && !echo_bad && exp_last
                   && (echo_data != exp_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      wait_cnt <= '0;
      exp_data <= '0;
      exp_last <= 1'b0;
    end else if (clear) begin
      pending  <= 1'b0;
      wait_cnt <= '0;
    end else if (accept) begin
      pending  <= 1'b1;
      wait_cnt <= '0;
      exp_data <= tx_data;
      exp_last <= tx_last;
    end else if (pending) begin
      if (echo_valid || expired) begin
        pending <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbt_watchdog.sv
module lbt_watchdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_active,
  input  logic [WD_W-1:0] limit,
  output logic            trip
);
  logic [WD_W-1:0] run_cnt;
  logic            tripped;

  assign trip = tx_active && !tripped && (limit != '0)
                && (run_cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_active) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else if (trip) begin
      tripped <= 1'b1;
    end else if (!tripped && limit != '0) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lbt_loopback_checker.sv
module lbt_loopback_checker #(
  parameter int DW       = 16,
  parameter int ECHO_WIN = 16,
  parameter int WD_W     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_en,
  input  logic            offline_sel,
  input  logic            irq_en,
  input  logic            msg_start,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_last,
  input  logic            tx_active,
  input  logic [WD_W-1:0] wdog_limit,
  input  logic            line_valid,
  input  logic [DW-1:0]   line_data,
  input  logic            line_par,
  input  logic            line_sync_err,
  input  logic            line_enc_err,
  input  logic            line_cnt_err,
  input  logic            wrap_valid,
  input  logic [DW-1:0]   wrap_data,
  input  logic            wrap_par,
  input  logic            wrap_sync_err,
  input  logic            wrap_enc_err,
  input  logic            wrap_cnt_err,
  output logic            loop_fail,
  output logic [2:0]      fail_cause,
  output logic            irq
);
  import lbt_pkg::*;

  logic [DW-1:0]      src_data [2];
  logic               echo_valid;
  logic [DW-1:0]      echo_data;
  logic               echo_bad;
  logic               fmt_evt;
  logic               cmp_evt;
  logic               wd_trip;
  logic [N_CAUSE-1:0] new_cause;
  logic [N_CAUSE-1:0] cause_q;
  logic               irq_q;

  assign src_data[PATH_LINE] = line_data;
  assign src_data[PATH_WRAP] = wrap_data;

  lbt_echo_select #(.DW(DW)) u_sel (
    .offline_sel  (offline_sel),
    .src_valid    ({wrap_valid, line_valid}),
    .src_data     (src_data),
    .src_par      ({wrap_par, line_par}),
    .src_flag_err ({wrap_sync_err | wrap_enc_err | wrap_cnt_err,
                    line_sync_err | line_enc_err | line_cnt_err}),
    .echo_valid   (echo_valid),
    .echo_data    (echo_data),
    .echo_bad     (echo_bad)
  );

  lbt_echo_tracker #(.DW(DW), .ECHO_WIN(ECHO_WIN)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (msg_start),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .echo_valid (echo_valid),
    .echo_data  (echo_data),
    .echo_bad   (echo_bad),
    .fmt_evt    (fmt_evt),
    .cmp_evt    (cmp_evt)
  );

  lbt_watchdog #(.WD_W(WD_W)) u_wdg (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .limit     (wdog_limit),
    .trip      (wd_trip)
  );

  always_comb begin
    new_cause            = '0;
    new_cause[CAUSE_FMT] = fmt_evt;
    new_cause[CAUSE_CMP] = cmp_evt;
    new_cause[CAUSE_WDG] = wd_trip;
    if (!test_en) new_cause = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || msg_start) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_q | new_cause;
      irq_q   <= irq_en && (cause_q == '0) && (new_cause != '0);
    end
  end

  assign fail_cause = cause_q;
  assign loop_fail  = |cause_q;
  assign irq        = irq_q;
endmodule

// File: rtl/lbt_loopback_sva.sv
module lbt_loopback_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       test_en,
  input logic       irq_en,
  input logic       msg_start,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_active,
  input logic [2:0] fail_cause,
  input logic       loop_fail,
  input logic       irq
);
  a_r11_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_start |=> ((fail_cause & $past(fail_cause)) == $past(fail_cause)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> (fail_cause == 3'b000 && !loop_fail));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_gated_first: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(irq_en) && loop_fail && $past(fail_cause) == 3'b000));

  a_r10_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !msg_start) |=> (fail_cause == $past(fail_cause)));

  a_r5_wdg_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_cause[2]) |-> $past(tx_active));
endmodule

bind lbt_loopback_checker lbt_loopback_sva u_sva (.*);

// File: tb/test_lbt_loopback_checker.sv
module test_lbt_loopback_checker;
  localparam int DW = 16;
  localparam int ECHO_WIN = 16;
  localparam int WD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b1, offline_sel = 1'b0, irq_en = 1'b1, msg_start = 1'b0;
  logic tx_valid = 1'b0, tx_last = 1'b0, tx_active = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic [WD_W-1:0] wdog_limit = '0;
  logic line_valid = 0, line_par = 0, line_sync_err = 0, line_enc_err = 0, line_cnt_err = 0;
  logic wrap_valid = 0, wrap_par = 0, wrap_sync_err = 0, wrap_enc_err = 0, wrap_cnt_err = 0;
  logic [DW-1:0] line_data = '0, wrap_data = '0;
  logic tx_ready, loop_fail, irq;
  logic [2:0] fail_cause;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;

  typedef struct {
    string      req;
    logic [2:0] cause;
    int         irqs;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  lbt_loopback_checker #(.DW(DW), .ECHO_WIN(ECHO_WIN), .WD_W(WD_W)) i_lbt_loopback_checker (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .offline_sel(offline_sel),
    .irq_en(irq_en), .msg_start(msg_start), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_active(tx_active), .wdog_limit(wdog_limit),
    .line_valid(line_valid), .line_data(line_data), .line_par(line_par),
    .line_sync_err(line_sync_err), .line_enc_err(line_enc_err), .line_cnt_err(line_cnt_err),
    .wrap_valid(wrap_valid), .wrap_data(wrap_data), .wrap_par(wrap_par),
    .wrap_sync_err(wrap_sync_err), .wrap_enc_err(wrap_enc_err), .wrap_cnt_err(wrap_cnt_err),
    .loop_fail(loop_fail), .fail_cause(fail_cause), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (msg_start) irq_cnt = 0;
    else if (irq) irq_cnt++;
  end

  // scoreboard monitor
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      e = exp_q.pop_front();
      check({e.req, " cause"}, {29'd0, fail_cause}, {29'd0, e.cause});
      check({e.req, " loop_fail"}, {31'd0, loop_fail}, {31'd0, |e.cause});
      check({e.req, " irq count"}, irq_cnt, e.irqs);
    end
  end

  task automatic expect_msg(input string req, input logic [2:0] cause, input int irqs);
    exp_t e;
    e.req = req; e.cause = cause; e.irqs = irqs;
    @(negedge clk);
    exp_q.push_back(e);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic start_msg();
    @(negedge clk); msg_start = 1'b1;
    @(negedge clk); msg_start = 1'b0;
  endtask

  // err bits: [0] sync, [1] encoding, [2] bit count, [3] flip parity
  task automatic xfer2(input logic [DW-1:0] d, input logic last, input int dly,
                       input logic [DW-1:0] ed, input logic [3:0] e_line, input logic [3:0] e_wrap);
    tx_valid = 1'b1; tx_data = d; tx_last = last;
    @(posedge clk);
    @(negedge clk); tx_valid = 1'b0;
    if (dly == 0) begin
      repeat (ECHO_WIN + 1) @(negedge clk);
    end else begin
      repeat (dly - 1) @(negedge clk);
      line_valid = 1'b1; line_data = ed; line_par = ~(^ed) ^ e_line[3];
      line_sync_err = e_line[0]; line_enc_err = e_line[1]; line_cnt_err = e_line[2];
      wrap_valid = 1'b1; wrap_data = ed; wrap_par = ~(^ed) ^ e_wrap[3];
      wrap_sync_err = e_wrap[0]; wrap_enc_err = e_wrap[1]; wrap_cnt_err = e_wrap[2];
      @(negedge clk);
      line_valid = 1'b0; wrap_valid = 1'b0;
      {line_sync_err, line_enc_err, line_cnt_err} = '0;
      {wrap_sync_err, wrap_enc_err, wrap_cnt_err} = '0;
    end
  endtask

  task automatic xfer(input logic [DW-1:0] d, input logic last, input int dly,
                      input logic [DW-1:0] ed, input logic [3:0] errs);
    xfer2(d, last, dly, ed, errs, errs);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 loop_fail", loop_fail, 0);
    check("R1 cause", fail_cause, 0);
    check("R1 irq", irq, 0);
    check("R1 tx_ready", tx_ready, 1);

    // R11 and clean message
    start_msg();
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 16'h1234; tx_last = 1'b0;
    @(posedge clk);
    @(negedge clk); tx_valid = 1'b0;
    check("R11 ready low while pending", tx_ready, 0);
    line_valid = 1'b1; line_data = 16'h1234; line_par = ~(^16'h1234);
    wrap_valid = 1'b1; wrap_data = 16'h1234; wrap_par = ~(^16'h1234);
    @(negedge clk); line_valid = 1'b0; wrap_valid = 1'b0;
    check("R11 ready back after echo", tx_ready, 1);
    xfer(16'h00FF, 1'b0, 2, 16'h00FF, 4'h0);
    xfer(16'hA5A5, 1'b1, 5, 16'hA5A5, 4'h0);
    expect_msg("R2 clean message", 3'b000, 0);

    // R3: mismatch on non-last ignored
    start_msg();
    xfer(16'h0F0F, 1'b0, 1, 16'h0F0E, 4'h0);
    xfer(16'h8001, 1'b1, 1, 16'h8001, 4'h0);
    expect_msg("R3 non-last mismatch ignored", 3'b000, 0);

    // R3 + R8: last mismatch
    start_msg();
    xfer(16'h8001, 1'b1, 3, 16'h8003, 4'h0);
    expect_msg("R3 last mismatch", 3'b010, 1);

    // R2 each format error kind
    for (int k = 0; k < 4; k++) begin
      start_msg();
      xfer(16'h3C3C, 1'b0, 2, 16'h3C3C, 4'(1 << k));
      expect_msg("R2 bad frame", 3'b001, 1);
    end

    // R7 + R8: accumulate, single irq
    start_msg();
    xfer(16'h1111, 1'b0, 1, 16'h1111, 4'h8);
    xfer(16'h2222, 1'b1, 1, 16'h2223, 4'h0);
    expect_msg("R7 accumulate R8 single irq", 3'b011, 1);
    start_msg();
    expect_msg("R7 cleared by msg_start", 3'b000, 0);

    // R4: echo missing
    start_msg();
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 16'h5555; tx_last = 1'b0;
    @(posedge clk);
    @(negedge clk); tx_valid = 1'b0;
    repeat (15) @(negedge clk);
    check("R4 no fail before window end", fail_cause, 0);
    @(negedge clk);
    check("R4 timeout at window end", fail_cause, 3'b001);
    check("R4 ready after timeout", tx_ready, 1);
    start_msg();
    xfer(16'h6666, 1'b1, ECHO_WIN, 16'h6666, 4'h0);
    expect_msg("R4 echo on last window edge", 3'b000, 0);

    // R5 watchdog
    start_msg();
    wdog_limit = 16'd10; tx_active = 1'b1;
    repeat (9) @(negedge clk);
    check("R5 before limit", fail_cause, 0);
    @(negedge clk);
    check("R5 at limit", fail_cause, 3'b100);
    tx_active = 1'b0;
    // R6 restart
    start_msg();
    tx_active = 1'b1;
    repeat (5) @(negedge clk);
    tx_active = 1'b0;
    @(negedge clk);
    tx_active = 1'b1;
    repeat (9) @(negedge clk);
    check("R6 restart count", fail_cause, 0);
    @(negedge clk);
    check("R6 trip after restart", fail_cause, 3'b100);
    tx_active = 1'b0;
    start_msg();
    wdog_limit = '0; tx_active = 1'b1;
    repeat (40) @(negedge clk);
    tx_active = 1'b0;
    expect_msg("R6 limit zero disables", 3'b000, 0);

    // R8 irq disabled
    irq_en = 1'b0;
    start_msg();
    xfer(16'h7777, 1'b1, 1, 16'h7770, 4'h0);
    expect_msg("R8 irq disabled", 3'b010, 0);
    irq_en = 1'b1;

    // R9 path select
    offline_sel = 1'b1;
    start_msg();
    xfer2(16'h4242, 1'b0, 2, 16'h4242, 4'h1, 4'h0);
    expect_msg("R9 offline ignores line", 3'b000, 0);
    start_msg();
    xfer2(16'h4242, 1'b0, 2, 16'h4242, 4'h0, 4'h2);
    expect_msg("R9 offline checks wrap", 3'b001, 1);
    offline_sel = 1'b0;
    start_msg();
    xfer2(16'h4242, 1'b0, 2, 16'h4242, 4'h0, 4'h4);
    expect_msg("R9 online ignores wrap", 3'b000, 0);

    // R10 test disabled
    test_en = 1'b0;
    start_msg();
    xfer(16'h9999, 1'b1, 1, 16'h9990, 4'h8);
    wdog_limit = 16'd3; tx_active = 1'b1;
    repeat (6) @(negedge clk);
    tx_active = 1'b0; wdog_limit = '0;
    expect_msg("R10 nothing recorded", 3'b000, 0);
    test_en = 1'b1;

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule